// File: doc/BRIEF.md
# Page-Mode DRAM Access Controller

This block sits on the host side of an asynchronous DRAM. It accepts one read or write at a time over a valid/ready handshake. Each request becomes a sequence of row-strobe, column-strobe, write-enable and output-enable levels on a single multiplexed address bus. The row part of the request address goes out first under the row strobe. The column part follows under the column strobe.

The controller keeps the row open after an access. A later request to the same row costs only a new column strobe. A request to a different row closes the page, waits out the precharge and opens the new row. The page also closes after a fixed number of idle cycles. Every delay is a parameter counted in clocks.

A mode input selects when read data is sampled. In fast-page capture, data is taken while the column strobe is still low. In extended-data-out capture, it is taken at the end of the column precharge, with output enable held low. The column strobe can therefore rise before the data is latched, which allows back-to-back pipelined reads. Writes always use early-write timing. Refresh arbitration and error correction belong to other blocks.

Top module: `pgdram_ctrl`

## Requirements
- R1: After reset the row strobe, column strobe, write enable and output enable are high (inactive), the data bus driver is off, `rd_valid` is low and `req_ready` is high.
- R2: The row address is the upper ROW_W bits of `req_addr` and is on `dram_addr` when the row strobe falls. The column address is the lower COL_W bits and is on `dram_addr` when the column strobe falls. The address is stable for as long as the column strobe is low.
- R3: Requests to the row that is already open are served with column strobes only, so a run of same-row requests produces exactly one row-strobe fall.
- R4: A request to a row other than the open one raises the row strobe. The row strobe stays high for at least T_RP cycles before it falls again.
- R5: With the page open and no request, the row strobe rises after IDLE_MAX open cycles. When the open state is entered from an extended-data-out read, this is the cycle after the IDLE_MAX-th cycle in which `rd_valid` was seen high.
- R6: The column strobe falls no earlier than T_RCD+1 cycles after the row strobe falls. It stays low exactly T_CAS cycles. Between two pulses within one page it stays high at least T_CP+1 cycles.
- R7: On writes, write enable is low at least one cycle before the column strobe falls. Output enable is high whenever write enable is low. The data bus is driven only while write enable is low.
- R8: With `edo_mode`=0, read data is sampled in the last cycle the column strobe is low, and output enable rises together with the column strobe.
- R9: With `edo_mode`=1, read data is sampled in the last cycle of column precharge, after the column strobe has risen, with output enable kept low from the column-strobe fall until that point.
- R10: Each read produces exactly one single-cycle `rd_valid` pulse, in request order, carrying the addressed word. Writes produce none.
- R11: The column strobe is never low while the row strobe is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| edo_mode | input | 1 | 0 = fast-page capture, 1 = extended-data-out capture; latched per request |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Word address, row in the upper bits |
| req_wdata | input | DATA_W | Write data |
| rd_valid | output | 1 | Read data valid pulse |
| rd_data | output | DATA_W | Captured read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_dq_out | output | DATA_W | Write data to the memory |
| dram_dq_oe | output | 1 | Drive enable for the data bus |
| dram_dq_in | input | DATA_W | Read data from the memory |

## Verification
The bound checker watches the strobe ordering on every cycle: no column strobe outside a row strobe, the minimum delay from row strobe to column strobe, the exact column pulse width, the row precharge length, early-write setup and exclusive write/output enables, address stability under the column strobe, and the output-enable level at the column-strobe rise in each capture mode. Three things only the bench scenarios can show: that the right word comes back in each capture mode against a memory model whose outputs float at different points, that page hits really avoid new row cycles, and that the idle timeout closes the page in the exact cycle.

// File: rtl/pgdram_pkg.sv
package pgdram_pkg;

   typedef enum logic [2:0] {
      ST_CLOSED,
      ST_RAS,
      ST_CSET,
      ST_CAS,
      ST_CPRE,
      ST_OPEN,
      ST_PRECH
   } pg_state_e;

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/pgdram_timer.sv
module pgdram_timer #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   output logic         done
);
   logic [W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= load_val;
      else if (cnt_q != '0)
         cnt_q <= cnt_q - 1'b1;
   end

   assign done = (cnt_q == '0);
endmodule

// File: rtl/pgdram_page.sv
module pgdram_page #(
   parameter int ROW_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             open_set,
   input  logic             open_clr,
   input  logic [ROW_W-1:0] set_row,
   input  logic [ROW_W-1:0] cmp_row,
   output logic             hit
);
   logic             valid_q;
   logic [ROW_W-1:0] row_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         row_q   <= '0;
      end else if (open_clr) begin
         valid_q <= 1'b0;
      end else if (open_set) begin
         valid_q <= 1'b1;
         row_q   <= set_row;
      end
   end

   assign hit = valid_q && (row_q == cmp_row);
endmodule

// File: rtl/pgdram_capture.sv
module pgdram_capture #(
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cap,
   input  logic [DATA_W-1:0] dq_in,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rd_valid <= 1'b0;
         rd_data  <= '0;
      end else begin
         rd_valid <= cap;
         if (cap) rd_data <= dq_in;
      end
   end
endmodule

// File: rtl/pgdram_ctrl.sv
module pgdram_ctrl
   import pgdram_pkg::*;
#(
   parameter int ROW_W    = 11,
   parameter int COL_W    = 10,
   parameter int DATA_W   = 16,
   parameter int T_RCD    = 2,
   parameter int T_CAS    = 2,
   parameter int T_CP     = 1,
   parameter int T_RP     = 3,
   parameter int IDLE_MAX = 12,
   localparam int AW      = imax(ROW_W, COL_W),
   localparam int ADDR_W  = ROW_W + COL_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              edo_mode,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rd_valid,
   output logic [DATA_W-1:0] rd_data,
   output logic              dram_ras_n,
   output logic              dram_cas_n,
   output logic              dram_we_n,
   output logic              dram_oe_n,
   output logic [AW-1:0]     dram_addr,
   output logic [DATA_W-1:0] dram_dq_out,
   output logic              dram_dq_oe,
   input  logic [DATA_W-1:0] dram_dq_in
);
   localparam int TMAX = imax(imax(imax(T_RCD, T_CAS), imax(T_CP, T_RP)), IDLE_MAX);
   localparam int TW   = $clog2(TMAX + 1);

   if (ROW_W < 1 || COL_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("pgdram_ctrl: widths must be positive");
   end
   if (T_RCD < 1 || T_CAS < 1 || T_CP < 1 || T_RP < 1 || IDLE_MAX < 1) begin : g_bad_timing
      $error("pgdram_ctrl: every timing count must be at least 1");
   end

   pg_state_e         state_q, state_d;
   logic              tdone, tload, hit, accept, cap;
   logic [TW-1:0]     tval;
   logic              cur_write, cur_edo;
   logic [ROW_W-1:0]  cur_row;
   logic [COL_W-1:0]  cur_col;
   logic [DATA_W-1:0] cur_wdata;
   logic [AW-1:0]     row_ext, col_ext;
   logic [ROW_W-1:0]  req_row;

   assign req_row = req_addr[ADDR_W-1:COL_W];

   // Address padding variant chosen by the narrower field
   if (ROW_W < AW) begin : g_row_pad
      assign row_ext = {{(AW-ROW_W){1'b0}}, cur_row};
   end else begin : g_row_full
      assign row_ext = cur_row;
   end
   if (COL_W < AW) begin : g_col_pad
      assign col_ext = {{(AW-COL_W){1'b0}}, cur_col};
   end else begin : g_col_full
      assign col_ext = cur_col;
   end

   assign req_ready = (state_q == ST_CLOSED) || (state_q == ST_OPEN && hit);
   assign accept    = req_valid && req_ready;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_CLOSED: if (req_valid) state_d = ST_RAS;
         ST_RAS:    if (tdone) state_d = ST_CSET;
         ST_CSET:   state_d = ST_CAS;
         ST_CAS:    if (tdone) state_d = ST_CPRE;
         ST_CPRE:   if (tdone) state_d = ST_OPEN;
         ST_OPEN: begin
            if (req_valid)  state_d = hit ? ST_CSET : ST_PRECH;
            else if (tdone) state_d = ST_PRECH;
         end
         ST_PRECH:  if (tdone) state_d = ST_CLOSED;
         default:   state_d = ST_CLOSED;
      endcase
   end

   always_comb begin
      unique case (state_d)
         ST_RAS:   tval = TW'(T_RCD - 1);
         ST_CAS:   tval = TW'(T_CAS - 1);
         ST_CPRE:  tval = TW'(T_CP - 1);
         ST_OPEN:  tval = TW'(IDLE_MAX - 1);
         ST_PRECH: tval = TW'(T_RP - 1);
         default:  tval = '0;
      endcase
   end
   assign tload = (state_d != state_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q   <= ST_CLOSED;
         cur_write <= 1'b0;
         cur_edo   <= 1'b0;
         cur_row   <= '0;
         cur_col   <= '0;
         cur_wdata <= '0;
      end else begin
         state_q <= state_d;
         if (accept) begin
            cur_write <= req_write;
            cur_edo   <= edo_mode;
            cur_row   <= req_row;
            cur_col   <= req_addr[COL_W-1:0];
            cur_wdata <= req_wdata;
         end
      end
   end

   pgdram_timer #(.W(TW)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tload),
      .load_val (tval),
      .done     (tdone)
   );

   pgdram_page #(.ROW_W(ROW_W)) u_page (
      .clk      (clk),
      .rst_n    (rst_n),
      .open_set (accept && state_q == ST_CLOSED),
      .open_clr (state_q == ST_OPEN && state_d == ST_PRECH),
      .set_row  (req_row),
      .cmp_row  (req_row),
      .hit      (hit)
   );

   assign cap = !cur_write && tdone &&
                ((state_q == ST_CAS  && !cur_edo) ||
                 (state_q == ST_CPRE &&  cur_edo));

   pgdram_capture #(.DATA_W(DATA_W)) u_cap (
      .clk      (clk),
      .rst_n    (rst_n),
      .cap      (cap),
      .dq_in    (dram_dq_in),
      .rd_valid (rd_valid),
      .rd_data  (rd_data)
   );

   assign dram_ras_n  = (state_q == ST_CLOSED) || (state_q == ST_PRECH);
   assign dram_cas_n  = (state_q != ST_CAS);
   assign dram_we_n   = !(cur_write && (state_q == ST_CSET || state_q == ST_CAS));
   assign dram_oe_n   = !(!cur_write &&
                          (state_q == ST_CAS || (state_q == ST_CPRE && cur_edo)));
   assign dram_addr   = (state_q == ST_RAS) ? row_ext : col_ext;
   assign dram_dq_out = cur_wdata;
   assign dram_dq_oe  = cur_write && (state_q == ST_CSET || state_q == ST_CAS);
endmodule

// File: rtl/pgdram_ctrl_chk.sv
module pgdram_ctrl_chk #(
   parameter int AW    = 11,
   parameter int T_RCD = 2,
   parameter int T_CAS = 2,
   parameter int T_RP  = 3
) (
   input logic          clk,
   input logic          rst_n,
   input logic          edo_mode,
   input logic          ras_n,
   input logic          cas_n,
   input logic          we_n,
   input logic          oe_n,
   input logic          dq_oe,
   input logic [AW-1:0] addr,
   input logic          rd_valid
);
   localparam logic [15:0] SAT = 16'hFFFF;
   logic [15:0] ras_lo, ras_hi, cas_lo;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ras_lo <= '0;
         ras_hi <= SAT;
         cas_lo <= '0;
      end else begin
         ras_lo <= ras_n ? '0 : ((ras_lo == SAT) ? SAT : ras_lo + 1'b1);
         ras_hi <= !ras_n ? '0 : ((ras_hi == SAT) ? SAT : ras_hi + 1'b1);
         cas_lo <= cas_n ? '0 : ((cas_lo == SAT) ? SAT : cas_lo + 1'b1);
      end
   end

   AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (!rst_n)
      !cas_n |-> !ras_n); // R11
   AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (!cas_n && $past(!cas_n)) |-> $stable(addr)); // R2
   AST_RCD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cas_n) |-> (ras_lo >= 16'(T_RCD + 1))); // R6
   AST_CAS_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cas_n) |-> (cas_lo == 16'(T_CAS))); // R6
   AST_RP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ras_n) |-> (ras_hi >= 16'(T_RP))); // R4
   AST_WE_SETUP: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(cas_n) && !we_n) |-> $past(!we_n)); // R7
   AST_WE_OE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !we_n |-> oe_n); // R7
   AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      dq_oe |-> !we_n); // R7
   AST_FPM_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_n) && !edo_mode) |-> oe_n); // R8
   AST_EDO_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(cas_n) && edo_mode && $past(!oe_n)) |-> !oe_n); // R9
   AST_RDV_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |=> !rd_valid); // R10
endmodule

bind pgdram_ctrl pgdram_ctrl_chk #(
   .AW(AW), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RP(T_RP)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .edo_mode (edo_mode),
   .ras_n    (dram_ras_n),
   .cas_n    (dram_cas_n),
   .we_n     (dram_we_n),
   .oe_n     (dram_oe_n),
   .dq_oe    (dram_dq_oe),
   .addr     (dram_addr),
   .rd_valid (rd_valid)
);

// File: tb/pgdram_ctrl_test.sv
module pgdram_ctrl_test;
   localparam int ROW_W = 11, COL_W = 10, DATA_W = 16;
   localparam int T_RCD = 2, T_CAS = 2, T_CP = 1, T_RP = 3, IDLE_MAX = 12;
   localparam int AW = 11, ADDR_W = ROW_W + COL_W;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n, edo_mode, req_valid, req_ready, req_write, rd_valid;
   logic [ADDR_W-1:0] req_addr;
   logic [DATA_W-1:0] req_wdata, rd_data, dq_out, dq_in;
   logic ras_n, cas_n, we_n, oe_n, dq_oe;
   logic [AW-1:0] daddr;

   pgdram_ctrl uut (
      .clk(clk), .rst_n(rst_n), .edo_mode(edo_mode),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rd_valid(rd_valid), .rd_data(rd_data),
      .dram_ras_n(ras_n), .dram_cas_n(cas_n), .dram_we_n(we_n), .dram_oe_n(oe_n),
      .dram_addr(daddr), .dram_dq_out(dq_out), .dram_dq_oe(dq_oe),
      .dram_dq_in(dq_in)
   );

   int checks = 0, fails = 0, ras_falls = 0, rd_seen = 0, rd_issued = 0;
   bit finished = 1'b0;
   logic [DATA_W-1:0] m_mem [int unsigned];
   logic [DATA_W-1:0] r_mem [int unsigned];
   logic [DATA_W-1:0] expq [$];
   logic [ADDR_W-1:0] cur_a;

   function automatic logic [DATA_W-1:0] seed_val(input int unsigned k);
      return DATA_W'((k * 32'd2654435761) >> 9);
   endfunction

   task automatic chk(input bit ok, input string rq, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h t=%0t", rq, act, exp, $time);
      end
   endtask

   // Memory model: outputs float per capture mode
   logic drv = 1'b0;
   logic [DATA_W-1:0] q_lat = '0;
   logic [ROW_W-1:0] m_row = '0;
   logic p_ras = 1'b1, p_cas = 1'b1, p_we = 1'b1;
   int ras_lo_run = 0, ras_hi_run = 1000, cas_lo_run = 0, cas_hi_run = 1000;
   assign dq_in = drv ? q_lat : 16'hDEAD;

   always @(negedge clk) begin
      if (rst_n) begin
         int unsigned key;
         if (p_ras && !ras_n) begin
            ras_falls++;
            m_row = daddr[ROW_W-1:0];
            chk(ras_hi_run >= T_RP, "R4", ras_hi_run, T_RP);
            chk(daddr[ROW_W-1:0] == cur_a[ADDR_W-1:COL_W], "R2", daddr, cur_a[ADDR_W-1:COL_W]);
            cas_hi_run = 1000;
         end
         if (!cas_n && ras_n) chk(0, "R11", cas_n, 1);
         if (p_cas && !cas_n) begin
            key = {m_row, daddr[COL_W-1:0]};
            chk(daddr[COL_W-1:0] == cur_a[COL_W-1:0], "R2", daddr, cur_a[COL_W-1:0]);
            chk(ras_lo_run >= T_RCD + 1, "R6", ras_lo_run, T_RCD + 1);
            if (cas_hi_run != 1000) chk(cas_hi_run >= T_CP + 1, "R6", cas_hi_run, T_CP + 1);
            if (!we_n) begin
               chk(!p_we && oe_n && dq_oe, "R7", {p_we, oe_n, dq_oe}, 3'b011);
               m_mem[key] = dq_out;
            end else begin
               q_lat = m_mem.exists(key) ? m_mem[key] : seed_val(key);
               drv = 1'b1;
            end
         end else if (ras_n || oe_n || (!edo_mode && cas_n)) begin
            drv = 1'b0;
         end
         if (!p_cas && cas_n) chk(cas_lo_run == T_CAS, "R6", cas_lo_run, T_CAS);
         if (rd_valid) begin
            rd_seen++;
            if (expq.size() == 0) chk(0, "R10", rd_data, 0);
            else begin
               logic [DATA_W-1:0] e;
               e = expq.pop_front();
               chk(rd_data == e, edo_mode ? "R9" : "R8", rd_data, e);
            end
         end
         ras_lo_run = ras_n ? 0 : ras_lo_run + 1;
         ras_hi_run = ras_n ? ras_hi_run + 1 : 0;
         cas_lo_run = cas_n ? 0 : cas_lo_run + 1;
         if (!cas_n) cas_hi_run = 0;
         else if (cas_hi_run != 1000) cas_hi_run++;
         p_ras = ras_n; p_cas = cas_n; p_we = we_n;
      end
   end

   task automatic do_req(input bit wr, input logic [ROW_W-1:0] row,
                         input logic [COL_W-1:0] col, input logic [DATA_W-1:0] d);
      int unsigned key;
      key = {row, col};
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = {row, col}; req_wdata = d;
      forever begin
         #1;
         if (req_ready) break;
         @(negedge clk);
      end
      cur_a = {row, col};
      if (wr) r_mem[key] = d;
      else begin
         expq.push_back(r_mem.exists(key) ? r_mem[key] : seed_val(key));
         rd_issued++;
      end
      @(posedge clk);
      #1 req_valid = 1'b0;
   endtask

   task automatic drain();
      repeat (IDLE_MAX + T_RP + 12) @(negedge clk);
   endtask

   task automatic report();
      if (!finished) begin
         finished = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(0, "watchdog", 0, 1);
      report();
   end

   initial begin
      int base;
      void'($urandom(32'd4242));
      rst_n = 1'b0; edo_mode = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_wdata = '0; cur_a = '0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk({ras_n, cas_n, we_n, oe_n} == 4'hF, "R1", {ras_n, cas_n, we_n, oe_n}, 4'hF);
      chk(!dq_oe && !rd_valid, "R1", {dq_oe, rd_valid}, 0);
      chk(req_ready, "R1", req_ready, 1);

      // Fast-page burst in one row: R3, R8, R10
      base = ras_falls;
      for (int c = 0; c < 4; c++) do_req(1'b1, 11'd5, 10'(c), 16'(16'h1100 + c));
      for (int c = 0; c < 4; c++) do_req(1'b0, 11'd5, 10'(c), '0);
      repeat (8) @(negedge clk);
      chk(ras_falls - base == 1, "R3", ras_falls - base, 1);
      chk(rd_seen == 4, "R10", rd_seen, 4);

      // Row miss: R4
      base = ras_falls;
      do_req(1'b1, 11'd5, 10'd7, 16'hBEEF);
      do_req(1'b0, 11'd9, 10'd7, '0);
      do_req(1'b0, 11'd5, 10'd7, '0);
      drain();
      chk(ras_falls - base == 2, "R4", ras_falls - base, 2);
      chk(ras_n, "R5", ras_n, 1);

      // Extended-data-out read and exact idle close: R9, R5
      edo_mode = 1'b1;
      do_req(1'b0, 11'd3, 10'd1, '0);
      do @(negedge clk); while (!rd_valid);
      repeat (IDLE_MAX - 1) @(negedge clk);
      chk(!ras_n, "R5", ras_n, 0);
      @(negedge clk);
      chk(ras_n, "R5", ras_n, 1);

      base = ras_falls;
      for (int c = 0; c < 3; c++) do_req(1'b1, 11'd4, 10'(c + 8), 16'(16'h4400 + c));
      for (int c = 0; c < 3; c++) do_req(1'b0, 11'd4, 10'(c + 8), '0);
      repeat (8) @(negedge clk);
      chk(ras_falls - base == 1, "R3", ras_falls - base, 1);
      drain();

      // Constrained random traffic, both capture modes
      for (int i = 0; i < 300; i++) begin
         if (i == 150) begin
            drain();
            edo_mode = 1'b0;
         end
         do_req(1'($urandom % 2), 11'(10 + $urandom % 3), 10'($urandom % 8),
                16'($urandom));
         repeat ($urandom % 3) @(negedge clk);
      end
      drain();
      chk(expq.size() == 0, "R10", expq.size(), 0);
      chk(rd_seen == rd_issued, "R10", rd_seen, rd_issued);
      report();
   end
endmodule